// File: doc/BRIEF.md
# Job Result Packager

This block sits between a processing engine and an output word FIFO. When a job is launched it latches the engine and job identifiers. It then sends a fixed start marker and the two identifiers. After that it passes the engine's result words through, one per handshake, with backpressure from the FIFO side carried back to the engine. It closes the job with a checksum word. The checksum makes the 32-bit wrapping sum of the identifiers, results and checksum equal zero.

The packager does not know the result length in advance. The engine ends its stream with a done pulse. That pulse may arrive before any result, together with the last result, or after it. The checksum is sent once done has been seen and no result is offered. While a job is in flight the block reports busy, and further launches are ignored.

Top module: `job_packager`

## Requirements
- R1: While reset is applied and just after it, `out_valid`, `res_ready` and `busy` are low.
- R2: The first word of every job is the start marker 0xE1E4C312.
- R3: Words leave in this order: marker, engine identifier, job identifier, each result word in arrival order, checksum.
- R4: The checksum word equals 2^32 minus ((engine id + job id + sum of results) mod 2^32), using 32-bit wrapping arithmetic.
- R5: A result word is consumed only on a cycle where `res_valid` and `res_ready` are both high. `res_ready` is high only in the result phase and only while `out_ready` is high.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change on the next cycle.
- R7: The checksum follows once `res_done` has been seen, whether it came before, together with or after the final result, and no result is offered.
- R8: `busy` rises on an accepted launch and falls only after the checksum has been taken. A `job_start` while busy changes neither the identifiers sent nor the checksum.
- R9: A job with no result words sends marker, identifiers, and a checksum over the two identifiers alone.
- R10: The running sum is cleared on each launch, so a job's checksum does not depend on earlier jobs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| job_start | input | 1 | Launch pulse; taken only when idle |
| mod_id | input | 32 | Engine identifier, latched at launch |
| job_id | input | 32 | Job identifier, latched at launch |
| busy | output | 1 | High from launch until the checksum is taken |
| res_data | input | 32 | Result word from the engine |
| res_valid | input | 1 | Result word offered |
| res_ready | output | 1 | Packager takes the offered result |
| res_done | input | 1 | Engine has no further results for this job |
| out_data | output | 32 | Packaged output word |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Downstream accepts the word |

## Verification
Jobs are sent with a downstream that is always ready and with one that stalls in a pseudo-random pattern. The first case checks the word order and the checksum arithmetic. The second checks that words are held and that each result is passed through exactly once. The done pulse is placed after the last result, together with it, and before the header finishes with zero results; these cases distinguish a correct done latch from one that loses the pulse or closes the job too early. One job uses identifiers that overflow the 32-bit sum and receives a second launch while busy. The job after it shows whether the sum is cleared and whether the late launch leaked into the output.

// File: rtl/jpk_pkg.sv
package jpk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_MID,
        ST_JID,
        ST_PAY,
        ST_SUM
    } jpk_state_e;
endpackage

// File: rtl/jpk_sum_acc.sv
module jpk_sum_acc #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] init,
    input  logic         add_en,
    input  logic [W-1:0] add_val,
    output logic [W-1:0] sum_q
);
    logic [W-1:0] sum_d;

    always_comb begin
        sum_d = sum_q;
        if (clear)
            sum_d = init;
        else if (add_en)
            sum_d = sum_q + add_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            sum_q <= '0;
        else
            sum_q <= sum_d;
    end

    p_clear_loads_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sum_q == $past(init)));

    p_add_wraps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !clear) |=> (sum_q == $past(sum_q) + $past(add_val)));
endmodule

// File: rtl/job_packager.sv
module job_packager
    import jpk_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter logic [31:0] PREAMBLE = 32'hE1E4C312
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              job_start,
    input  logic [DATA_W-1:0] mod_id,
    input  logic [DATA_W-1:0] job_id,
    output logic              busy,
    input  logic [DATA_W-1:0] res_data,
    input  logic              res_valid,
    output logic              res_ready,
    input  logic              res_done,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);
    localparam logic [DATA_W-1:0] MARKER = DATA_W'(PREAMBLE);

    typedef struct packed {
        jpk_state_e        state;
        logic [DATA_W-1:0] mid;
        logic [DATA_W-1:0] jid;
        logic              done_seen;
    } pk_regs_t;

    pk_regs_t          r_d, r_q;
    logic              acc_clear, acc_add;
    logic [DATA_W-1:0] acc_init, acc_sum;

    jpk_sum_acc #(.W(DATA_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (acc_clear),
        .init    (acc_init),
        .add_en  (acc_add),
        .add_val (res_data),
        .sum_q   (acc_sum)
    );

    always_comb begin
        r_d       = r_q;
        acc_clear = 1'b0;
        acc_add   = 1'b0;
        acc_init  = mod_id + job_id;
        out_valid = 1'b0;
        out_data  = '0;
        res_ready = 1'b0;

        if (res_done && r_q.state != ST_IDLE)
            r_d.done_seen = 1'b1;

        case (r_q.state)
            ST_IDLE: begin
                if (job_start) begin
                    r_d.mid       = mod_id;
                    r_d.jid       = job_id;
                    r_d.done_seen = 1'b0;
                    r_d.state     = ST_PRE;
                    acc_clear     = 1'b1;
                end
            end
            ST_PRE: begin
                out_valid = 1'b1;
                out_data  = MARKER;
                if (out_ready) r_d.state = ST_MID;
            end
            ST_MID: begin
                out_valid = 1'b1;
                out_data  = r_q.mid;
                if (out_ready) r_d.state = ST_JID;
            end
            ST_JID: begin
                out_valid = 1'b1;
                out_data  = r_q.jid;
                if (out_ready) r_d.state = ST_PAY;
            end
            ST_PAY: begin
                out_valid = res_valid;
                out_data  = res_data;
                res_ready = out_ready;
                if (res_valid) begin
                    if (out_ready) acc_add = 1'b1;
                end else if (r_q.done_seen || res_done) begin
                    r_d.state = ST_SUM;
                end
            end
            ST_SUM: begin
                out_valid = 1'b1;
                out_data  = '0 - acc_sum;
                if (out_ready) begin
                    r_d.state     = ST_IDLE;
                    r_d.done_seen = 1'b0;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state     <= ST_IDLE;
            r_q.mid       <= '0;
            r_q.jid       <= '0;
            r_q.done_seen <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = (r_q.state != ST_IDLE);

    p_first_marker_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (out_valid && out_data == MARKER));

    p_take_only_with_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ready) |-> (out_valid && out_ready && out_data == res_data));

    p_hold_under_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && r_q.state != ST_PAY) |=> (out_valid && $stable(out_data)));

    p_busy_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(out_valid && out_ready));

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && job_start) |=> ($stable(r_q.mid) && $stable(r_q.jid)));
endmodule

// File: tb/job_packager_bench.sv
`timescale 1ns/100ps
module job_packager_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        job_start;
    logic [31:0] mod_id, job_id;
    logic        busy;
    logic [31:0] res_data;
    logic        res_valid, res_ready, res_done;
    logic [31:0] out_data;
    logic        out_valid, out_ready;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    logic       stall_mode = 1'b0;
    logic [7:0] lfsr = 8'h5a;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        prev_stall = 1'b0;
    logic [31:0] prev_data = '0;
    bit          summary_done = 0;

    always #2.5 clk = ~clk;

    job_packager u_job_packager (
        .clk(clk), .rst_n(rst_n), .job_start(job_start), .mod_id(mod_id),
        .job_id(job_id), .busy(busy), .res_data(res_data), .res_valid(res_valid),
        .res_ready(res_ready), .res_done(res_done), .out_data(out_data),
        .out_valid(out_valid), .out_ready(out_ready)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: sets downstream ready at negedge, samples before next posedge
    always begin
        @(negedge clk);
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = stall_mode ? (lfsr[0] | lfsr[2]) : 1'b1;
        #2;
        if (rst_n) begin
            if (prev_stall) begin
                check("R6 valid held", {31'd0, out_valid}, 32'd1);
                check("R6 data held", out_data, prev_data);
            end
            if (res_ready) check("R5 ready needs out_ready", {31'd0, out_ready}, 32'd1);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check("R3 unexpected word", out_data, 32'hxxxxxxxx);
                end else begin
                    check(tag_q.pop_front(), out_data, exp_q.pop_front());
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !summary_done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            summary_done = 1;
            $finish;
        end
    end

    // done_mode: 0 after last word, 1 with last word, 2 before any word (n==0 only)
    task automatic run_job(input logic [31:0] mid, input logic [31:0] jid, input int n,
                           input logic [31:0] base, input int gap, input int done_mode,
                           input bit poke, input string tg);
        logic [31:0] s;
        s = mid + jid;
        exp_q.push_back(32'hE1E4C312); tag_q.push_back({"R2 marker ", tg});
        exp_q.push_back(mid);          tag_q.push_back({"R3 module id ", tg});
        exp_q.push_back(jid);          tag_q.push_back({"R3 job id ", tg});
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(base + i * 32'h01010101);
            tag_q.push_back({"R3 result ", tg});
            s = s + base + i * 32'h01010101;
        end
        exp_q.push_back(32'd0 - s);    tag_q.push_back({"R4/R7 checksum ", tg});

        @(negedge clk);
        job_start = 1'b1; mod_id = mid; job_id = jid;
        @(negedge clk);
        job_start = 1'b0;
        if (done_mode == 2) begin
            res_done = 1'b1;
            @(negedge clk);
            res_done = 1'b0;
        end
        if (poke) begin
            job_start = 1'b1; mod_id = 32'hDEAD0001; job_id = 32'hDEAD0002;
            @(negedge clk);
            job_start = 1'b0;
        end
        for (int i = 0; i < n; i++) begin
            logic took;
            res_valid = 1'b1;
            res_data  = base + i * 32'h01010101;
            if (done_mode == 1 && i == n - 1) res_done = 1'b1;
            took = 1'b0;
            while (!took) begin
                #2;
                took = res_ready;
                @(negedge clk);
            end
            res_valid = 1'b0;
            res_done  = 1'b0;
            res_data  = 32'h0;
            repeat (gap) @(negedge clk);
        end
        if (done_mode == 0) begin
            res_done = 1'b1;
            @(negedge clk);
            res_done = 1'b0;
        end
        while (busy) @(negedge clk);
        #2;
        check({"R8 busy released ", tg}, {31'd0, busy}, 32'd0);
        check({"R3 all words seen ", tg}, exp_q.size(), 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; job_start = 1'b0; mod_id = '0; job_id = '0;
        res_data = '0; res_valid = 1'b0; res_done = 1'b0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
        check("R1 res_ready in reset", {31'd0, res_ready}, 32'd0);
        check("R1 busy in reset", {31'd0, busy}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1 busy after reset", {31'd0, busy}, 32'd0);

        run_job(32'hF218E0A2, 32'h12345678, 4, 32'h1, 0, 0, 0, "job1");
        stall_mode = 1'b1;
        run_job(32'h2CB31E7C, 32'h00000042, 6, 32'hA5000000, 2, 1, 0, "job2 R5");
        run_job(32'h9323EB24, 32'h0000BEEF, 0, 32'h0, 0, 2, 0, "job3 R9");
        run_job(32'hFFFFFFF0, 32'h00000020, 5, 32'hFFFFFF00, 1, 0, 1, "job4 R8");
        stall_mode = 1'b0;
        run_job(32'h4CD2E19C, 32'h00000007, 3, 32'h10, 0, 1, 0, "job5 R10");
        stall_mode = 1'b1;
        run_job(32'h00000001, 32'h00000002, 0, 32'h0, 0, 0, 0, "job6 R9");

        repeat (4) @(negedge clk);
        if (!summary_done) begin
            summary_done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        end
        $finish;
    end
endmodule